// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address that a burst-capable synchronous memory presents to its array on every beat. On a load cycle it takes a full start address from its input; on each advance cycle after that it moves the low bits to the next beat of the burst. The low bits step in one of two orders: a wrapping count upward, or an order in which the start bits are XORed with the beat number. The upper bits stay as they were loaded.

The order is chosen by a mode input that is meant to be tied off. The block samples it together with the start address, so a burst keeps the order it began with. An active-low clock enable freezes every register, which suspends a burst in place. The burst length is 2**BEAT_W beats, with a default of four.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and after it is released until the first load, addr_out is all zeros.
- R2: On a rising edge with clk_en_n low and adv_n_ld low, addr_out takes the value of addr_in after that edge.
- R3: With linear order (order_sel low at load), each edge with clk_en_n low and adv_n_ld high raises the low BEAT_W bits of addr_out by one, modulo 2**BEAT_W. For a start of 2 with BEAT_W of 2 this gives 2,3,0,1.
- R4: With interleaved order (order_sel high at load), the low BEAT_W bits on beat n equal the start low bits XOR n. For a start of 1 this gives 1,0,3,2.
- R5: After 2**BEAT_W advances the low bits are back at the start value, and further advances repeat the sequence.
- R6: Advance cycles never change addr_out bits ADDR_W-1 down to BEAT_W.
- R7: On an edge with clk_en_n high, addr_out keeps its value whatever adv_n_ld, order_sel and addr_in are.
- R8: order_sel is sampled only on load edges. Changing it during a burst does not alter the order of that burst.
- R9: A load in the middle of a burst restarts at beat zero from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| adv_n_ld | input | 1 | High advances the burst, low loads addr_in |
| order_sel | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with ADDR_W of 8 and the default BEAT_W of 2. With these values the upper six bits are short enough for the bench to load distinctive patterns and see any corruption during a burst. Every start value in both orders fits in a short run, so the bench sweeps them all, and each sweep runs past one full burst so that the wrap is covered.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] lo_out
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] xor_lo;

    assign lin_lo = start_lo + beat;

    // one XOR per address bit
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
        assign xor_lo[b] = start_lo[b] ^ beat[b];
    end

    always_comb begin
        case (order)
            ORDER_XOR: lo_out = xor_lo;
            default:   lo_out = lin_lo;
        endcase
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    output logic [BEAT_W-1:0] beat_q
);
    logic [BEAT_W-1:0] beat_d;

    always_comb begin
        beat_d = beat_q;
        if (run) begin
            if (load) beat_d = '0;
            else      beat_d = beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    // a load puts the counter at beat zero
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && load) |=> (beat_q == '0));

    // an advance steps by one and wraps after the last beat
    assert_wrap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              adv_n_ld,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UP_W-1:0]   upper;
        logic [BEAT_W-1:0] start_lo;
        burst_order_e      order;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    logic              run;
    logic              load;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] lo_now;

    assign run  = !clk_en_n;
    assign load = !adv_n_ld;

    always_comb begin
        st_d = st_q;
        if (run && load) begin
            st_d.upper    = addr_in[ADDR_W-1:BEAT_W];
            st_d.start_lo = addr_in[BEAT_W-1:0];
            st_d.order    = burst_order_e'(order_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{upper: '0, start_lo: '0, order: ORDER_LINEAR};
        else        st_q <= st_d;
    end

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .load   (load),
        .beat_q (beat_q)
    );

    burst_order_gen #(.BEAT_W(BEAT_W)) u_order (
        .start_lo (st_q.start_lo),
        .beat     (beat_q),
        .order    (st_q.order),
        .lo_out   (lo_now)
    );

    assign addr_out = {st_q.upper, lo_now};

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && load) |=> (addr_out == $past(addr_in)));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(addr_out));

    assert_upper_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && st_q.order == ORDER_LINEAR) |=>
        (addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1)));
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int ADDR_W = 8;
    localparam int BEAT_W = 2;
    localparam int NBEAT  = 1 << BEAT_W;

    typedef struct {
        logic [ADDR_W-1:0] exp;
        string             tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_en_n = 1'b1;
    logic              adv_n_ld = 1'b1;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    item_t sb[$];

    // reference state from the requirements
    logic [ADDR_W-BEAT_W-1:0] m_upper = '0;
    logic [BEAT_W-1:0]        m_start = '0;
    logic [BEAT_W-1:0]        m_beat  = '0;
    logic                     m_xor   = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_n_ld(adv_n_ld),
        .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
    );

    function automatic logic [ADDR_W-1:0] model_addr();
        logic [BEAT_W-1:0] lo;
        lo = m_xor ? (m_start ^ m_beat) : BEAT_W'(m_start + m_beat);
        return {m_upper, lo};
    endfunction

    task automatic step(input logic ce_n, input logic adv, input logic mode,
                        input logic [ADDR_W-1:0] a, input string tag);
        item_t it;
        @(negedge clk);
        clk_en_n  = ce_n;
        adv_n_ld  = adv;
        order_sel = mode;
        addr_in   = a;
        if (!ce_n) begin
            if (!adv) begin
                m_upper = a[ADDR_W-1:BEAT_W];
                m_start = a[BEAT_W-1:0];
                m_beat  = '0;
                m_xor   = mode;
            end else begin
                m_beat = m_beat + 1'b1;
            end
        end
        it.exp = model_addr();
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic check_now(input logic [ADDR_W-1:0] exp, input string tag);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, exp);
        end
    endtask

    // monitor: compare one expected item per clock, after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check_now(it.exp, it.tag);
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check_now('0, "R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk) #1 check_now('0, "R1 after reset");

        // R3 and R5: linear from 2 gives 2,3,0,1 then back to 2
        step(0, 0, 0, 8'hA6, "R2 load linear");
        for (int i = 0; i < NBEAT + 1; i++) step(0, 1, 0, 8'h00, "R3 R5 R6 linear advance");

        // R4: interleaved from 1 gives 1,0,3,2
        step(0, 0, 1, 8'h5D, "R2 load xor");
        for (int i = 0; i < NBEAT + 1; i++) step(0, 1, 1, 8'hFF, "R4 R5 R6 xor advance");

        // R7: frozen cycles ignore every input
        step(0, 0, 0, 8'h32, "R2 load before freeze");
        step(0, 1, 0, 8'h00, "R3 advance before freeze");
        step(1, 0, 1, 8'hC1, "R7 freeze with load");
        step(1, 1, 0, 8'h77, "R7 freeze with advance");
        step(0, 1, 0, 8'h00, "R7 resume after freeze");

        // R8: mode flip mid-burst is ignored
        step(0, 0, 0, 8'h91, "R2 load linear from 1");
        step(0, 1, 1, 8'h00, "R8 mode flip linear");
        step(0, 1, 1, 8'h00, "R8 mode flip linear");
        step(0, 0, 1, 8'h4E, "R2 load xor from 2");
        step(0, 1, 0, 8'h00, "R8 mode flip xor");
        step(0, 1, 0, 8'h00, "R8 mode flip xor");

        // R9: load mid-burst restarts
        step(0, 0, 1, 8'hE7, "R9 reload mid-burst");
        step(0, 1, 1, 8'h00, "R9 first beat after reload");

        // sweep every start value in both orders
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < NBEAT; s++) begin
                step(0, 0, m[0], ADDR_W'(8'h84 | s), "R2 sweep load");
                for (int i = 0; i < NBEAT + 1; i++)
                    step(0, 1, m[0], 8'h00, m == 0 ? "R3 R5 sweep" : "R4 R5 sweep");
            end
        end

        @(negedge clk);
        clk_en_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule